// File: doc/BRIEF.md
# Handshaked Byte Link Shifter

This block is the peripheral end of a half-duplex byte link to a host processor. The host drives two active-low level lines: an in-progress line that frames a packet and an acknowledge line that it toggles once per byte. The block answers on an active-low request line. Every byte crosses an 8-bit shift register. The host writes and reads that register directly, and a direction input chooses which way the bytes flow.

When the host sends, each change on either handshake line stores the shift register into the next slot of a capture buffer. When in-progress goes inactive, the block ends the packet and reports the number of captured bytes with a one-cycle strobe. The consumer then reads the captured bytes through a synchronous read port.

When the host receives, a local agent first writes a reply packet into a reply buffer and commits its length. Each handshake change then moves the next reply byte into the shift register, and the request line tells the host whether reply data is still waiting. Every byte-level event sets an interrupt flag after a programmable number of cycles. The flag is set at once instead when the port-B direction register reads all ones. A read of the shift register clears the flag.

Top module: `hsb_shifter`

## Requirements
- R1: After reset, req_n is 1, irq is 0, pkt_valid is 0 and sr_q is 0x00. The capture count and the reply index and length are all 0.
- R2: With dir_send=1 and inprog_n=0, each cycle in which inprog_n or ack_n differs from its previous-cycle value writes sr_q into the next capture slot, starting at slot 0. The slot can be read on cap_rd_data one cycle after cap_rd_addr is presented.
- R3: Once CAP_DEPTH bytes have been captured, further handshake changes in that packet store nothing. The reported length saturates at CAP_DEPTH.
- R4: When inprog_n rises from 0 to 1 with at least one byte captured, pkt_valid is high for exactly one cycle with pkt_len equal to the byte count, and the next packet starts again at slot 0. With no bytes captured, pkt_valid stays low.
- R5: Every rise of inprog_n requests an interrupt, even when no byte moved.
- R6: With dir_send=0 and inprog_n=0, each handshake change loads the next committed reply byte into sr_q while reply bytes remain. Once the reply is used up, sr_q no longer changes.
- R7: The handshake change that loads the last reply byte drives req_n to 1.
- R8: A rise of inprog_n while reply bytes remain drives req_n to 0.
- R9: When inprog_n is 1 in both the previous and the current cycle and ack_n changes, req_n is driven to 1 and an interrupt is requested.
- R10: An interrupt request sets irq exactly DELAY_CYC cycles after the request edge. When ddrb is 0xFF, irq is set on the request edge itself. A new request while a countdown is running restarts the countdown.
- R11: A pulse on sr_rd clears irq on the next edge unless a new interrupt is set on that same edge.
- R12: rep_commit resets the reply index to 0, stores rep_commit_len (at most REP_DEPTH) and requests an interrupt. It does not change req_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inprog_n | input | 1 | Host transfer-in-progress line, active low, synchronous to clk |
| ack_n | input | 1 | Host acknowledge line, toggled once per byte, synchronous to clk |
| dir_send | input | 1 | 1: host sends bytes to the block; 0: host receives reply bytes |
| ddrb | input | 8 | Port-B direction register value; 0xFF selects an undelayed interrupt |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wr_data | input | 8 | Data for a host write to the shift register |
| sr_rd | input | 1 | Host read strobe for the shift register; clears irq |
| sr_q | output | 8 | Shift register contents |
| req_n | output | 1 | Request line to the host, active low |
| irq | output | 1 | Byte-level interrupt flag |
| pkt_valid | output | 1 | One-cycle strobe for a completed host packet |
| pkt_len | output | CAP_CNT_W | Byte count of the completed packet |
| cap_rd_addr | input | CAP_AW | Capture buffer read address |
| cap_rd_data | output | 8 | Capture buffer read data, one cycle after the address |
| rep_wr | input | 1 | Reply buffer write strobe |
| rep_wr_addr | input | REP_AW | Reply buffer write address |
| rep_wr_data | input | 8 | Reply buffer write data |
| rep_commit | input | 1 | Commit a reply packet of rep_commit_len bytes |
| rep_commit_len | input | REP_CNT_W | Length of the committed reply |

## Verification
A wrong capture count shows at the next rise of inprog_n, either as a wrong pkt_len or as data in the wrong capture slot. A wrong reply index shows on sr_q at the very handshake change that uses it. A slip in the request-line logic shows on req_n one edge after the last-byte load, the idle sync or the end of a transfer. A wrong delay count shows as irq rising one cycle early or late against the DELAY_CYC window, so the bench samples irq on both sides of that window, including the restart case.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  // Decoded handshake events for one clock edge
  typedef struct packed {
    logic capture;  // store shift register into capture buffer
    logic load;     // move next reply byte into shift register
    logic last;     // the load is the final reply byte
    logic finish;   // in-progress went inactive
    logic sync;     // idle acknowledge toggle
  } hs_evt_t;
endpackage

// File: rtl/hsb_ram.sv
module hsb_ram #(
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter bit SYNC_RD = 1'b1,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  generate
    if (SYNC_RD) begin : g_sync
      always_ff @(posedge clk) rd_data <= mem[rd_addr];
    end else begin : g_async
      assign rd_data = mem[rd_addr];
    end
  endgenerate
endmodule

// File: rtl/hsb_irq_delay.sv
module hsb_irq_delay #(
  parameter int DELAY_CYC = 30000,
  localparam int DLY_W    = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic imm,
  input  logic clr,
  output logic flag
);
  logic             pend;
  logic [DLY_W-1:0] cnt;
  logic             fire;

  assign fire = pend && (cnt == DLY_W'(1)) && !req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (req) begin
        pend <= !imm;
        cnt  <= DLY_W'(DELAY_CYC);
      end else if (pend) begin
        if (cnt == DLY_W'(1)) pend <= 1'b0;
        else                  cnt  <= cnt - 1'b1;
      end
      if ((req && imm) || fire) flag <= 1'b1;
      else if (clr)             flag <= 1'b0;
    end
  end

  AST_IMM_FIRE: assert property (@(posedge clk) disable iff (rst)
    req && imm |=> flag); // R10
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr && !req && !pend |=> !flag); // R11
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    req && !imm && !flag && !clr && (DELAY_CYC > 1) |=> !flag); // R10
endmodule

// File: rtl/hsb_link_ctrl.sv
module hsb_link_ctrl
  import hsb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inprog_n,
  input  logic    ack_n,
  input  logic    dir_send,
  input  logic    cap_room,
  input  logic    rep_more,
  input  logic    rep_last,
  output hs_evt_t evt,
  output logic    irq_req
);
  logic prv_ip_n, prv_ack_n;
  logic chg, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_ip_n  <= 1'b1;
      prv_ack_n <= 1'b1;
    end else begin
      prv_ip_n  <= inprog_n;
      prv_ack_n <= ack_n;
    end
  end

  assign chg    = (inprog_n != prv_ip_n) || (ack_n != prv_ack_n);
  assign active = !inprog_n;

  always_comb begin
    evt         = '0;
    evt.capture = active && dir_send && chg && cap_room;
    evt.load    = active && !dir_send && chg && rep_more;
    evt.last    = evt.load && rep_last;
    evt.finish  = !active && !prv_ip_n;
    evt.sync    = !active && prv_ip_n && (ack_n != prv_ack_n);
  end

  assign irq_req = evt.capture | evt.load | evt.finish | evt.sync;

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.capture, evt.load, evt.finish, evt.sync})); // R2
endmodule

// File: rtl/hsb_shifter.sv
module hsb_shifter
  import hsb_pkg::*;
#(
  parameter int CAP_DEPTH  = 16,
  parameter int REP_DEPTH  = 16,
  parameter int DELAY_CYC  = 30000,
  localparam int CAP_AW    = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1,
  localparam int REP_AW    = (REP_DEPTH > 1) ? $clog2(REP_DEPTH) : 1,
  localparam int CAP_CNT_W = $clog2(CAP_DEPTH + 1),
  localparam int REP_CNT_W = $clog2(REP_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inprog_n,
  input  logic                 ack_n,
  input  logic                 dir_send,
  input  logic [7:0]           ddrb,
  input  logic                 sr_wr,
  input  logic [7:0]           sr_wr_data,
  input  logic                 sr_rd,
  output logic [7:0]           sr_q,
  output logic                 req_n,
  output logic                 irq,
  output logic                 pkt_valid,
  output logic [CAP_CNT_W-1:0] pkt_len,
  input  logic [CAP_AW-1:0]    cap_rd_addr,
  output logic [7:0]           cap_rd_data,
  input  logic                 rep_wr,
  input  logic [REP_AW-1:0]    rep_wr_addr,
  input  logic [7:0]           rep_wr_data,
  input  logic                 rep_commit,
  input  logic [REP_CNT_W-1:0] rep_commit_len
);
  hs_evt_t               evt;
  logic                  irq_evt;
  logic [CAP_CNT_W-1:0]  cap_cnt;
  logic [REP_CNT_W-1:0]  rep_idx, rep_len;
  logic                  cap_room, rep_more, rep_last;
  logic [7:0]            rep_rd_data;

  assign cap_room = cap_cnt < CAP_CNT_W'(CAP_DEPTH);
  assign rep_more = rep_idx < rep_len;
  assign rep_last = (rep_idx + REP_CNT_W'(1)) >= rep_len;

  hsb_link_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inprog_n (inprog_n),
    .ack_n    (ack_n),
    .dir_send (dir_send),
    .cap_room (cap_room),
    .rep_more (rep_more),
    .rep_last (rep_last),
    .evt      (evt),
    .irq_req  (irq_evt)
  );

  // Capture buffer: synchronous read, block-RAM friendly
  hsb_ram #(.W(8), .DEPTH(CAP_DEPTH), .SYNC_RD(1'b1)) u_cap_ram (
    .clk     (clk),
    .wr_en   (evt.capture),
    .wr_addr (cap_cnt[CAP_AW-1:0]),
    .wr_data (sr_q),
    .rd_addr (cap_rd_addr),
    .rd_data (cap_rd_data)
  );

  // Reply buffer: asynchronous read so a byte moves on the handshake edge
  hsb_ram #(.W(8), .DEPTH(REP_DEPTH), .SYNC_RD(1'b0)) u_rep_ram (
    .clk     (clk),
    .wr_en   (rep_wr),
    .wr_addr (rep_wr_addr),
    .wr_data (rep_wr_data),
    .rd_addr (rep_idx[REP_AW-1:0]),
    .rd_data (rep_rd_data)
  );

  hsb_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .req  (irq_evt | rep_commit),
    .imm  (ddrb == 8'hFF),
    .clr  (sr_rd),
    .flag (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= '0;
      cap_cnt   <= '0;
      rep_idx   <= '0;
      rep_len   <= '0;
      req_n     <= 1'b1;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else begin
      // shift register: a reply load wins over a host write
      if (evt.load)   sr_q <= rep_rd_data;
      else if (sr_wr) sr_q <= sr_wr_data;

      // capture count and packet report
      pkt_valid <= evt.finish && (cap_cnt != '0);
      if (evt.finish) begin
        pkt_len <= cap_cnt;
        cap_cnt <= '0;
      end else if (evt.capture) begin
        cap_cnt <= cap_cnt + 1'b1;
      end

      // reply index and length
      if (rep_commit) begin
        rep_idx <= '0;
        rep_len <= rep_commit_len;
      end else if (evt.load) begin
        rep_idx <= rep_idx + 1'b1;
      end

      // request line
      if (evt.last || evt.sync)      req_n <= 1'b1;
      else if (evt.finish && rep_more) req_n <= 1'b0;
    end
  end

  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    cap_cnt <= CAP_CNT_W'(CAP_DEPTH)); // R3
  AST_PKT_RESTART: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_len != '0) && (cap_cnt == '0)); // R4
  AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst)
    rep_idx <= rep_len); // R6
  AST_LAST_REQ: assert property (@(posedge clk) disable iff (rst)
    evt.last |=> req_n); // R7
  AST_SYNC_REQ: assert property (@(posedge clk) disable iff (rst)
    evt.sync |=> req_n); // R9
  AST_COMMIT_LEN: assert property (@(posedge clk) disable iff (rst)
    rep_commit |-> rep_commit_len <= REP_CNT_W'(REP_DEPTH)); // R12
endmodule

// File: tb/hsb_shifter_bench.sv
module hsb_shifter_bench;
  localparam int CAP_DEPTH = 4;
  localparam int REP_DEPTH = 8;
  localparam int DLY       = 12;
  localparam int CAP_AW    = $clog2(CAP_DEPTH);
  localparam int REP_AW    = $clog2(REP_DEPTH);
  localparam int CAP_CNT_W = $clog2(CAP_DEPTH + 1);
  localparam int REP_CNT_W = $clog2(REP_DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inprog_n = 1'b1, ack_n = 1'b1, dir_send = 1'b1;
  logic [7:0] ddrb = 8'hFF;
  logic sr_wr = 1'b0, sr_rd = 1'b0, rep_wr = 1'b0, rep_commit = 1'b0;
  logic [7:0] sr_wr_data = '0, rep_wr_data = '0;
  logic [REP_AW-1:0] rep_wr_addr = '0;
  logic [REP_CNT_W-1:0] rep_commit_len = '0;
  logic [CAP_AW-1:0] cap_rd_addr = '0;
  logic [7:0] sr_q, cap_rd_data;
  logic req_n, irq, pkt_valid;
  logic [CAP_CNT_W-1:0] pkt_len;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsb_shifter #(.CAP_DEPTH(CAP_DEPTH), .REP_DEPTH(REP_DEPTH), .DELAY_CYC(DLY)) u_hsb_shifter (
    .clk(clk), .rst(rst), .inprog_n(inprog_n), .ack_n(ack_n), .dir_send(dir_send),
    .ddrb(ddrb), .sr_wr(sr_wr), .sr_wr_data(sr_wr_data), .sr_rd(sr_rd), .sr_q(sr_q),
    .req_n(req_n), .irq(irq), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .cap_rd_addr(cap_rd_addr), .cap_rd_data(cap_rd_data), .rep_wr(rep_wr),
    .rep_wr_addr(rep_wr_addr), .rep_wr_data(rep_wr_data), .rep_commit(rep_commit),
    .rep_commit_len(rep_commit_len)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_sr(input logic [7:0] v);
    sr_wr = 1'b1; sr_wr_data = v; tick(); sr_wr = 1'b0;
  endtask

  task automatic read_sr();
    sr_rd = 1'b1; tick(); sr_rd = 1'b0;
  endtask

  task automatic set_ip(input logic v);
    inprog_n = v; tick();
  endtask

  task automatic toggle_ack();
    ack_n = ~ack_n; tick();
  endtask

  task automatic load_reply(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rep_wr = 1'b1; rep_wr_addr = REP_AW'(i); rep_wr_data = base + 8'(i); tick();
    end
    rep_wr = 1'b0;
    rep_commit = 1'b1; rep_commit_len = REP_CNT_W'(n); tick(); rep_commit = 1'b0;
  endtask

  task automatic chk_cap(input int a, input logic [7:0] exp, input string tag);
    cap_rd_addr = CAP_AW'(a); tick();
    chk(cap_rd_data == exp, tag, cap_rd_data, exp);
  endtask

  task automatic t_reset();
    chk(req_n == 1'b1, "R1 req_n", req_n, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(pkt_valid == 1'b0, "R1 pkt_valid", pkt_valid, 0);
    chk(sr_q == 8'h00, "R1 sr_q", sr_q, 0);
  endtask

  task automatic t_send();
    ddrb = 8'hFF; dir_send = 1'b1;
    write_sr(8'hA1); set_ip(1'b0);
    write_sr(8'hB2); toggle_ack();
    write_sr(8'hC3); toggle_ack();
    read_sr();
    chk(irq == 1'b0, "R11 irq cleared by read", irq, 0);
    set_ip(1'b1);
    chk(pkt_valid == 1'b1, "R4 pkt_valid", pkt_valid, 1);
    chk(pkt_len == 3, "R4 pkt_len", pkt_len, 3);
    chk(irq == 1'b1, "R5 irq at end", irq, 1);
    tick();
    chk(pkt_valid == 1'b0, "R4 single-cycle strobe", pkt_valid, 0);
    chk_cap(0, 8'hA1, "R2 slot0");
    chk_cap(1, 8'hB2, "R2 slot1");
    chk_cap(2, 8'hC3, "R2 slot2");
  endtask

  task automatic t_overflow();
    dir_send = 1'b1;
    write_sr(8'h10); set_ip(1'b0);
    for (int i = 1; i < 6; i++) begin
      write_sr(8'h10 + 8'(i)); toggle_ack();
    end
    set_ip(1'b1);
    chk(pkt_valid == 1'b1 && pkt_len == CAP_CNT_W'(CAP_DEPTH), "R3 saturated len", pkt_len, CAP_DEPTH);
    chk_cap(0, 8'h10, "R4 new packet at slot0");
    chk_cap(3, 8'h13, "R3 last stored slot");
  endtask

  task automatic t_empty_end();
    dir_send = 1'b0;
    read_sr();
    set_ip(1'b0);
    chk(irq == 1'b0, "R6 no reply no event", irq, 0);
    set_ip(1'b1);
    chk(pkt_valid == 1'b0, "R4 empty no strobe", pkt_valid, 0);
    chk(irq == 1'b1, "R5 irq on empty end", irq, 1);
  endtask

  task automatic t_receive();
    dir_send = 1'b1;
    write_sr(8'h55); set_ip(1'b0);
    read_sr();
    load_reply(3, 8'hD0);
    chk(irq == 1'b1, "R12 commit irq", irq, 1);
    chk(req_n == 1'b1, "R12 commit keeps req_n", req_n, 1);
    set_ip(1'b1);
    chk(pkt_valid == 1'b1 && pkt_len == 1, "R4 one-byte packet", pkt_len, 1);
    chk(req_n == 1'b0, "R8 req_n low with reply pending", req_n, 0);
    dir_send = 1'b0;
    set_ip(1'b0);
    chk(sr_q == 8'hD0, "R6 byte0", sr_q, 8'hD0);
    chk(req_n == 1'b0, "R7 req_n low mid reply", req_n, 0);
    toggle_ack();
    chk(sr_q == 8'hD1, "R6 byte1", sr_q, 8'hD1);
    toggle_ack();
    chk(sr_q == 8'hD2, "R6 byte2", sr_q, 8'hD2);
    chk(req_n == 1'b1, "R7 req_n high after last", req_n, 1);
    toggle_ack();
    chk(sr_q == 8'hD2, "R6 exhausted holds", sr_q, 8'hD2);
    set_ip(1'b1);
    chk(req_n == 1'b1, "R8 no pending stays high", req_n, 1);
    chk(pkt_valid == 1'b0, "R4 receive no strobe", pkt_valid, 0);
  endtask

  task automatic t_sync();
    dir_send = 1'b1;
    write_sr(8'h77); set_ip(1'b0);
    load_reply(2, 8'hE0);
    set_ip(1'b1);
    chk(req_n == 1'b0, "R8 req_n low", req_n, 0);
    read_sr();
    toggle_ack();
    chk(req_n == 1'b1, "R9 idle sync req_n", req_n, 1);
    chk(irq == 1'b1, "R9 idle sync irq", irq, 1);
  endtask

  task automatic t_delay();
    ddrb = 8'h00;
    read_sr();
    toggle_ack();
    repeat (DLY - 1) tick();
    chk(irq == 1'b0, "R10 not before delay", irq, 0);
    tick();
    chk(irq == 1'b1, "R10 set at delay", irq, 1);
    read_sr();
    toggle_ack();
    repeat (5) tick();
    toggle_ack();
    repeat (DLY - 6) tick();
    chk(irq == 1'b0, "R10 restart cancels first", irq, 0);
    repeat (5) tick();
    chk(irq == 1'b0, "R10 restart not early", irq, 0);
    tick();
    chk(irq == 1'b1, "R10 restart fires", irq, 1);
    ddrb = 8'hFF;
    read_sr();
    toggle_ack();
    chk(irq == 1'b1, "R10 immediate with ddrb all ones", irq, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_send();
    t_overflow();
    t_empty_end();
    t_receive();
    t_sync();
    t_delay();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule